// File: doc/BRIEF.md
# Page-Load Write Controller

This block sits between the byte-wide write bus of a 32K x 8 non-volatile memory and its page buffer. It turns active-low chip-select, output-enable and write-strobe inputs, sampled on the system clock, into single writes into a 64-byte page buffer. Each accepted byte restarts an inter-byte timer. When that timer runs out, the block starts a programming cycle of fixed length.

A load begins with any accepted byte. Later bytes must address the same page, meaning the same upper address bits. A byte for another page throws the whole collected load away, and no programming cycle follows. While programming runs, the block is busy and ignores write strobes. When the cycle ends it gives a one-clock done pulse together with a buffer-clear pulse. The protection logic can veto any byte through an allow input. The address of the last accepted byte stays on an output for the status logic.

Top module: `page_load_ctrl`

## Requirements
- R1: A byte is taken only from a strobe during which ce_n and we_n are both 0 and oe_n is 1. Every other combination of the three inputs leaves buf_we at 0 and the controller idle.
- R2: The address is registered on the first clock at which the qualified strobe is seen active. The data is the last value sampled while the strobe is active. buf_we pulses for exactly one clock, on the clock after the first edge that finds the strobe inactive again.
- R3: On buf_we, buf_idx equals address bits 5..0 and buf_data equals the captured byte. prog_page holds address bits 14..6 of the load's first byte.
- R4: During a load, a byte with different bits 14..6 writes nothing. It pulses buf_clr, drops the load, and causes no prog_start.
- R5: Every accepted byte restarts the load timer. prog_start rises LOAD_CYC clocks after the buf_we of the last byte, as a one-clock pulse.
- R6: ltmr_stat is 0 from an accepted byte until the timer expires or the load is dropped, and 1 at all other times.
- R7: busy is 1 for exactly WRITE_CYC clocks, starting with prog_start. In the first clock after busy falls, prog_done and buf_clr pulse together.
- R8: Write strobes that end while busy is 1 produce no buf_we, leave last_addr unchanged and do not change the busy length.
- R9: A strobe that ends while wr_allow is 0 is ignored. It writes nothing, starts no load and does not restart the timer.
- R10: last_addr holds the full address of the most recently accepted byte.
- R11: After reset, buf_we, buf_clr, busy, prog_start and prog_done are 0 and ltmr_stat is 1.
- R12: After prog_done, a byte on any page, including the highest page, starts a new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| wr_allow | input | 1 | Write permission from the protection logic |
| buf_we | output | 1 | Page buffer write enable, one clock |
| buf_idx | output | log2(PAGE_BYTES) | Byte offset within the page |
| buf_data | output | DATA_W | Byte written into the page buffer |
| buf_clr | output | 1 | Page buffer clear pulse |
| prog_page | output | ADDR_W-log2(PAGE_BYTES) | Page of the current load |
| prog_start | output | 1 | Programming cycle start pulse |
| prog_done | output | 1 | Programming cycle end pulse |
| busy | output | 1 | Programming cycle in progress |
| ltmr_stat | output | 1 | 0 while the load timer runs, 1 otherwise |
| last_addr | output | ADDR_W | Address of the last accepted byte |

## Verification
The hardest case to reach from the ports is a write strobe that finishes inside the programming window. The bench waits for prog_start and then runs a complete byte write while busy is still high. It then checks that the busy length stays WRITE_CYC and that nothing reaches the buffer. A second hard case is timer restart just before expiry. The bench spaces bytes at gaps just under LOAD_CYC and checks that the start pulse counts from the last byte only. A vetoed byte placed inside a load shows the matching case from the other side: that byte must not restart the timer.

// File: rtl/pgl_pkg.sv
package pgl_pkg;
   typedef enum logic [1:0] {
      PGL_IDLE = 2'd0,
      PGL_LOAD = 2'd1,
      PGL_PROG = 2'd2
   } pgl_state_e;
endpackage

// File: rtl/pgl_strobe.sv
module pgl_strobe #(
   parameter int ADDR_W  = 15,
   parameter int DATA_W  = 8,
   parameter int IN_SYNC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic              commit,
   output logic [ADDR_W-1:0] cap_addr,
   output logic [DATA_W-1:0] cap_data
);
   logic              ce_s, oe_s, we_s;
   logic [ADDR_W-1:0] addr_s;
   logic [DATA_W-1:0] din_s;

   generate
      if (IN_SYNC != 0) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ce_s   <= 1'b1;
               oe_s   <= 1'b1;
               we_s   <= 1'b1;
               addr_s <= '0;
               din_s  <= '0;
            end else begin
               ce_s   <= ce_n;
               oe_s   <= oe_n;
               we_s   <= we_n;
               addr_s <= addr;
               din_s  <= din;
            end
         end
      end else begin : g_pass
         always_comb begin
            ce_s   = ce_n;
            oe_s   = oe_n;
            we_s   = we_n;
            addr_s = addr;
            din_s  = din;
         end
      end
   endgenerate

   // qualified write strobe: select and write low, output enable high
   logic act, act_q;
   assign act    = !ce_s && !we_s && oe_s;
   assign commit = act_q && !act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q    <= 1'b0;
         cap_addr <= '0;
         cap_data <= '0;
      end else begin
         act_q <= act;
         if (act && !act_q) cap_addr <= addr_s;
         if (act)           cap_data <= din_s;
      end
   end
endmodule

// File: rtl/pgl_timer.sv
module pgl_timer #(
   parameter int LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   output logic hit
);
   localparam int CW = $clog2(LIMIT + 1);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("pgl_timer: LIMIT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign hit = run && !start && (cnt == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (start || !run)  cnt <= '0;
      else if (!hit)           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl
   import pgl_pkg::*;
#(
   parameter int ADDR_W     = 15,
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 64,
   parameter int LOAD_CYC   = 12500,
   parameter int WRITE_CYC  = 625000,
   parameter int IN_SYNC    = 0,
   localparam int IDX_W     = $clog2(PAGE_BYTES),
   localparam int PAGE_W    = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              wr_allow,
   output logic              buf_we,
   output logic [IDX_W-1:0]  buf_idx,
   output logic [DATA_W-1:0] buf_data,
   output logic              buf_clr,
   output logic [PAGE_W-1:0] prog_page,
   output logic              prog_start,
   output logic              prog_done,
   output logic              busy,
   output logic              ltmr_stat,
   output logic [ADDR_W-1:0] last_addr
);
   generate
      if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
         $error("page_load_ctrl: PAGE_BYTES must be a power of two");
      end
      if (ADDR_W <= IDX_W) begin : g_bad_addr
         $error("page_load_ctrl: ADDR_W must exceed the page offset width");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("page_load_ctrl: DATA_W must be positive");
      end
   endgenerate

   logic              commit;
   logic [ADDR_W-1:0] cap_addr;
   logic [DATA_W-1:0] cap_data;

   pgl_strobe #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .IN_SYNC(IN_SYNC)
   ) u_strobe (
      .clk     (clk),
      .rst_n   (rst_n),
      .ce_n    (ce_n),
      .oe_n    (oe_n),
      .we_n    (we_n),
      .addr    (addr),
      .din     (din),
      .commit  (commit),
      .cap_addr(cap_addr),
      .cap_data(cap_data)
   );

   pgl_state_e        state;
   logic [PAGE_W-1:0] page_q;
   logic              accept, same_pg, ld_hit, wc_hit;

   assign accept  = commit && wr_allow && (state != PGL_PROG);
   assign same_pg = (cap_addr[ADDR_W-1:IDX_W] == page_q);

   pgl_timer #(.LIMIT(LOAD_CYC)) u_load_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .start(accept),
      .run  (state == PGL_LOAD),
      .hit  (ld_hit)
   );

   pgl_timer #(.LIMIT(WRITE_CYC)) u_wc_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .start(ld_hit),
      .run  (state == PGL_PROG),
      .hit  (wc_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= PGL_IDLE;
         page_q     <= '0;
         last_addr  <= '0;
         buf_we     <= 1'b0;
         buf_idx    <= '0;
         buf_data   <= '0;
         buf_clr    <= 1'b0;
         prog_start <= 1'b0;
         prog_done  <= 1'b0;
      end else begin
         buf_we     <= 1'b0;
         buf_clr    <= 1'b0;
         prog_start <= 1'b0;
         prog_done  <= 1'b0;
         case (state)
            PGL_IDLE: begin
               if (accept) begin
                  state     <= PGL_LOAD;
                  page_q    <= cap_addr[ADDR_W-1:IDX_W];
                  last_addr <= cap_addr;
                  buf_we    <= 1'b1;
                  buf_idx   <= cap_addr[IDX_W-1:0];
                  buf_data  <= cap_data;
               end
            end
            PGL_LOAD: begin
               if (accept) begin
                  if (same_pg) begin
                     last_addr <= cap_addr;
                     buf_we    <= 1'b1;
                     buf_idx   <= cap_addr[IDX_W-1:0];
                     buf_data  <= cap_data;
                  end else begin
                     state   <= PGL_IDLE;
                     buf_clr <= 1'b1;
                  end
               end else if (ld_hit) begin
                  state      <= PGL_PROG;
                  prog_start <= 1'b1;
               end
            end
            PGL_PROG: begin
               if (wc_hit) begin
                  state     <= PGL_IDLE;
                  prog_done <= 1'b1;
                  buf_clr   <= 1'b1;
               end
            end
            default: state <= PGL_IDLE;
         endcase
      end
   end

   assign prog_page = page_q;
   assign busy      = (state == PGL_PROG);
   assign ltmr_stat = (state != PGL_LOAD);
endmodule

// File: rtl/page_load_chk.sv
module page_load_chk #(
   parameter int PAGE_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              buf_we,
   input logic              buf_clr,
   input logic              busy,
   input logic              ltmr_stat,
   input logic              prog_start,
   input logic              prog_done,
   input logic [PAGE_W-1:0] prog_page
);
   AST_WE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |=> !buf_we);                                         // R2
   AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_we && $past(!ltmr_stat)) |-> $stable(prog_page));       // R3
   AST_LOAD_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> !ltmr_stat);                                      // R6
   AST_BUSY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ltmr_stat);                                         // R6
   AST_BUSY_BEGIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> prog_start);                                 // R7
   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |-> busy);                                        // R7
   AST_DONE_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
      prog_done |-> (!busy && $past(busy) && buf_clr));            // R7
   AST_NO_WE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !buf_we);                                           // R8
endmodule

bind page_load_ctrl page_load_chk #(.PAGE_W(PAGE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .buf_we    (buf_we),
   .buf_clr   (buf_clr),
   .busy      (busy),
   .ltmr_stat (ltmr_stat),
   .prog_start(prog_start),
   .prog_done (prog_done),
   .prog_page (prog_page)
);

// File: tb/tb_page_load_ctrl.sv
module tb_page_load_ctrl;
   localparam int AW = 15;
   localparam int DW = 8;
   localparam int PB = 64;
   localparam int LC = 8;
   localparam int WC = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic          wr_allow = 1'b1;
   logic          buf_we, buf_clr, prog_start, prog_done, busy, ltmr_stat;
   logic [5:0]    buf_idx;
   logic [DW-1:0] buf_data;
   logic [8:0]    prog_page;
   logic [AW-1:0] last_addr;

   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   page_load_ctrl #(
      .ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB),
      .LOAD_CYC(LC), .WRITE_CYC(WC), .IN_SYNC(0)
   ) dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .din(din), .wr_allow(wr_allow),
      .buf_we(buf_we), .buf_idx(buf_idx), .buf_data(buf_data),
      .buf_clr(buf_clr), .prog_page(prog_page), .prog_start(prog_start),
      .prog_done(prog_done), .busy(busy), .ltmr_stat(ltmr_stat),
      .last_addr(last_addr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // strobe with address/data possibly changing in the second cycle
   task automatic do_wr(input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                        input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                        input logic late_ce, input logic allow);
      @(negedge clk);
      addr = a0; din = d0; we_n = 1'b0; oe_n = 1'b1; ce_n = late_ce; wr_allow = allow;
      @(negedge clk);
      addr = a1; din = d1; ce_n = 1'b0;
      @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic raw_strobe(input logic c, input logic o, input logic w);
      @(negedge clk);
      ce_n = c; oe_n = o; we_n = w; wr_allow = 1'b1;
      @(negedge clk);
      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr_ok(input logic [AW-1:0] a, input logic [DW-1:0] d);
      do_wr(a, a, d, d, 1'b0, 1'b1);
      chk("R3 buf_we", 32'(buf_we), 32'd1);
      chk("R3 buf_idx", 32'(buf_idx), 32'(a[5:0]));
      chk("R3 buf_data", 32'(buf_data), 32'(d));
      chk("R10 last_addr", 32'(last_addr), 32'(a));
      chk("R6 ltmr_stat low", 32'(ltmr_stat), 32'd0);
   endtask

   task automatic wait_prog(input int pg, input int exp_k, input bit intrude);
      int k = 0;
      int b = 0;
      bit stat_hi = 0;
      logic [AW-1:0] la;
      while (!prog_start && k < 200) begin
         @(negedge clk);
         k++;
         if (!prog_start && ltmr_stat) stat_hi = 1;
      end
      chk("R5 start delay", 32'(k), 32'(exp_k));
      chk("R6 status low while timing", 32'(stat_hi), 32'd0);
      chk("R3 prog_page", 32'(prog_page), 32'(pg));
      if (intrude) begin
         la = last_addr;
         do_wr({9'd1, 6'd1}, {9'd1, 6'd1}, 8'h5A, 8'h5A, 1'b0, 1'b1);
         chk("R8 no write while busy", 32'(buf_we), 32'd0);
         chk("R8 last_addr kept", 32'(last_addr), 32'(la));
         b = 4;
      end
      while (busy && b < 500) begin
         b++;
         @(negedge clk);
      end
      chk("R7 busy length", 32'(b), 32'(WC));
      chk("R7 prog_done", 32'(prog_done), 32'd1);
      chk("R7 buf_clr", 32'(buf_clr), 32'd1);
      chk("R6 status high after", 32'(ltmr_stat), 32'd1);
      @(negedge clk);
      chk("R7 done one clock", 32'(prog_done), 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [AW-1:0] la;
      int k;
      bit seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 buf_we", 32'(buf_we), 32'd0);
      chk("R11 buf_clr", 32'(buf_clr), 32'd0);
      chk("R11 busy", 32'(busy), 32'd0);
      chk("R11 prog_start", 32'(prog_start), 32'd0);
      chk("R11 prog_done", 32'(prog_done), 32'd0);
      chk("R11 ltmr_stat", 32'(ltmr_stat), 32'd1);

      // R1 sweep of control combinations
      for (int c = 0; c < 8; c++) begin
         if (c != 3'b010) begin
            addr = {9'd4, 6'(c)};
            raw_strobe(c[2], c[1], c[0]);
            chk("R1 no write", 32'(buf_we), 32'd0);
            chk("R1 idle", 32'(ltmr_stat), 32'd1);
         end
      end
      wr_ok({9'd3, 6'd5}, 8'hC3);
      wait_prog(3, LC, 1'b0);

      // R3 full page sweep, then R8 intrusion while busy
      for (int i = 0; i < PB; i++) begin
         wr_ok({9'd300, 6'(i)}, 8'((i * 37 + 11) & 255));
      end
      wait_prog(300, LC, 1'b1);

      // R2 address at later falling edge, data at last active sample
      do_wr({9'd7, 6'd1}, {9'd7, 6'd9}, 8'h11, 8'h99, 1'b1, 1'b1);
      chk("R2 late addr idx", 32'(buf_idx), 32'd9);
      chk("R2 late data", 32'(buf_data), 32'h99);
      chk("R2 we", 32'(buf_we), 32'd1);
      do_wr({9'd7, 6'd2}, {9'd7, 6'd33}, 8'h22, 8'h77, 1'b0, 1'b1);
      chk("R2 early addr idx", 32'(buf_idx), 32'd2);
      chk("R2 early data", 32'(buf_data), 32'h77);
      @(negedge clk);
      chk("R2 pulse one clock", 32'(buf_we), 32'd0);
      wait_prog(7, LC - 1, 1'b0);

      // R9 veto when idle and during a load
      la = last_addr;
      do_wr({9'd8, 6'd0}, {9'd8, 6'd0}, 8'h01, 8'h01, 1'b0, 1'b0);
      chk("R9 no write idle", 32'(buf_we), 32'd0);
      chk("R9 no load", 32'(ltmr_stat), 32'd1);
      chk("R9 last_addr kept", 32'(last_addr), 32'(la));
      wr_ok({9'd9, 6'd4}, 8'h44);
      do_wr({9'd9, 6'd5}, {9'd9, 6'd5}, 8'h55, 8'h55, 1'b0, 1'b0);
      chk("R9 no write in load", 32'(buf_we), 32'd0);
      wait_prog(9, LC - 4, 1'b0);

      // R4 foreign page drops the load
      wr_ok({9'd20, 6'd0}, 8'hA0);
      do_wr({9'd21, 6'd0}, {9'd21, 6'd0}, 8'hB0, 8'hB0, 1'b0, 1'b1);
      chk("R4 no write", 32'(buf_we), 32'd0);
      chk("R4 buf_clr", 32'(buf_clr), 32'd1);
      chk("R4 status high", 32'(ltmr_stat), 32'd1);
      chk("R4 last_addr", 32'(last_addr), 32'({9'd20, 6'd0}));
      seen = 0;
      for (int j = 0; j < LC + 4; j++) begin
         @(negedge clk);
         if (prog_start || busy) seen = 1;
      end
      chk("R4 no programming", 32'(seen), 32'd0);

      // R5 retrigger near expiry, R12 top page
      wr_ok({9'd511, 6'd63}, 8'hF0);
      repeat (3) @(negedge clk);
      wr_ok({9'd511, 6'd0}, 8'hF1);
      repeat (3) @(negedge clk);
      wr_ok({9'd511, 6'd31}, 8'hF2);
      k = 0;
      wait_prog(511, LC, 1'b0);
      wr_ok({9'd0, 6'd0}, 8'h0F);
      chk("R12 new load page", 32'(prog_page), 32'd0);
      wait_prog(0, LC, 1'b0);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule